// File: doc/BRIEF.md
# Bus Controller Descriptor Sequencer

This block runs a list of bus-controller messages out of a shared 16-bit RAM. Software fills a circular stack of four-word descriptors (status word, time tag, a spare word, data-block address), writes the address of the first descriptor into a fixed pointer location, and writes the number of messages to send, in ones complement, into a fixed count location. A pulse on `start_i` then sets the sequencer going. For each message it reads the pointer, marks the descriptor as in progress, stamps the time tag, loads the data-block address into a register that the attached protocol device uses, and gives the device a one-cycle kick.

When the protocol device reports end of message, together with its error indications, the sequencer writes the final status word and a fresh time tag. It then moves the pointer on by one descriptor, wrapping inside the stack, and steps the count. It raises one-cycle events for the end of each message, for a message with errors, and for the end of the whole list. With the stop-on-error control set, a message that had an error ends the run after its bookkeeping is done. The next start picks up at the following descriptor.

The RAM port is a request channel with valid/ready flow control. A request (address, write enable, write data) is presented with `mem_valid_o` and holds unchanged until `mem_ready_i` is seen high at a clock edge. For a read, the RAM returns the word on `mem_rdata_i` in the cycle after the accepting edge. The sequencer never has more than one request in flight.

Top module: `bc_desc_seq`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `mem_valid_o`, `bc_start_o` and all three event outputs are low until a start is accepted.
- R2: After an accepted start, the RAM requests come in this order: a read of the pointer location, a write of 0x0002 (in-progress flag at bit 1) to the descriptor's first word, and a write of the time tag to its second word. A read of its fourth word follows, and that word appears on `data_addr_o`. Only then is `bc_start_o` high, for exactly one cycle.
- R3: A `start_i` pulse while `busy_o` is high is ignored: no extra kick and no extra message.
- R4: At end of message the first descriptor word is rewritten. Bit 0 is the done flag and bit 1 is cleared. Bits 11, 10, 9 and 8 carry loop fail, timeout, format error and status set as sampled with `eom_i`. Bit 12 is their OR and bit 13 (channel) is 0. The second word is rewritten with the time tag taken at end of message.
- R5: The pointer location is rewritten with the pointer plus four after every message, error or not. The low log2(4 x STACK_ENTRIES) bits wrap and the upper bits are kept.
- R6: The count location is incremented after every message. When the new value is 0xFFFF, `done_evt_o` pulses and the sequencer goes idle.
- R7: `eom_evt_o` pulses once per message. `err_evt_o` pulses together with it when any error input was set for that message.
- R8: With `stop_on_err_i` high at the end of a message that had an error, the sequencer goes idle after its bookkeeping. A new start resumes at the next descriptor with the remaining count.
- R9: A RAM request keeps its address, write enable and write data stable while `mem_valid_o` is high and `mem_ready_i` is low. Read data is taken in the cycle after acceptance.
- R10: With `stop_on_err_i` low, messages with errors do not stop the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command pulse |
| stop_on_err_i | input | 1 | Halt after a message with an error |
| eom_i | input | 1 | End-of-message pulse from the protocol device |
| loop_fail_i | input | 1 | Loop test failed, valid with `eom_i` |
| timeout_i | input | 1 | No response, valid with `eom_i` |
| format_err_i | input | 1 | Message format error, valid with `eom_i` |
| status_set_i | input | 1 | Status word had bits set, valid with `eom_i` |
| tag_i | input | 16 | Free-running time tag value |
| mem_valid_o | output | 1 | RAM request valid |
| mem_ready_i | input | 1 | RAM accepts the request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after acceptance |
| bc_start_o | output | 1 | One-cycle kick to the protocol device |
| data_addr_o | output | ADDR_W | Data-block address register |
| busy_o | output | 1 | A list is running |
| eom_evt_o | output | 1 | One message finished |
| err_evt_o | output | 1 | The finished message had an error |
| done_evt_o | output | 1 | The list is finished |

## Verification
The end of the list and the halt on error can both fall on the same message. The bench provokes this by running a one-message list with a format error and stop-on-error set, as well as every error pattern over a single message. It then expects `done_evt_o` and `err_evt_o` in the same cycle as `eom_evt_o`, with the count at 0xFFFF and the sequencer idle. A halt in the middle of a list, followed by a restart, and a start poked while a message is in flight are judged by the kick count and by the RAM contents the bench computes from the pointer arithmetic.

// File: rtl/bc_seq_pkg.sv
package bc_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_SP,
    ST_RD_SP_D,
    ST_WR_SOM,
    ST_WR_TAG0,
    ST_RD_DBA,
    ST_RD_DBA_D,
    ST_KICK,
    ST_WAIT,
    ST_WR_BSW,
    ST_WR_TAG1,
    ST_WR_SP,
    ST_RD_CNT,
    ST_RD_CNT_D,
    ST_WR_CNT
  } seq_state_e;

  localparam int BSW_DONE = 0;
  localparam int BSW_BUSY = 1;
  localparam int BSW_FLG  = 8;   // four error flags at 11..8
  localparam int BSW_ANY  = 12;

  localparam logic [15:0] CNT_LAST = 16'hFFFF;

  typedef struct packed {
    logic loop_fail;
    logic timeout;
    logic format_err;
    logic status_set;
  } err_flags_t;

endpackage

// File: rtl/bc_seq_ptr.sv
module bc_seq_ptr #(
  parameter int ADDR_W        = 16,
  parameter int STACK_ENTRIES = 64
) (
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] ptr_next_o,
  input  logic [15:0]       cnt_i,
  output logic [15:0]       cnt_next_o,
  output logic              cnt_last_o
);
  import bc_seq_pkg::*;

  localparam int SPAN_W = $clog2(STACK_ENTRIES * 4);

  generate
    if (SPAN_W >= ADDR_W) begin : g_flat
      assign ptr_next_o = ptr_i + ADDR_W'(4);
    end else begin : g_wrap
      assign ptr_next_o = {ptr_i[ADDR_W-1:SPAN_W], ptr_i[SPAN_W-1:0] + SPAN_W'(4)};
    end
  endgenerate

  assign cnt_next_o = cnt_i + 16'd1;
  assign cnt_last_o = (cnt_next_o == CNT_LAST);

endmodule

// File: rtl/bc_seq_status.sv
module bc_seq_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture_i,
  input  logic        loop_fail_i,
  input  logic        timeout_i,
  input  logic        format_err_i,
  input  logic        status_set_i,
  output logic [15:0] bsw_o,
  output logic        any_err_o
);
  import bc_seq_pkg::*;

  err_flags_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (capture_i) begin
      flags_q <= '{loop_fail: loop_fail_i, timeout: timeout_i,
                   format_err: format_err_i, status_set: status_set_i};
    end
  end

  assign any_err_o = |flags_q;

  always_comb begin
    bsw_o = '0;
    bsw_o[BSW_DONE] = 1'b1;
    bsw_o[BSW_FLG +: 4] = flags_q;
    bsw_o[BSW_ANY] = any_err_o;
  end

endmodule

// File: rtl/bc_seq_fsm.sv
module bc_seq_fsm #(
  parameter int ADDR_W = 16,
  parameter int unsigned SP_ADDR  = 'h100,
  parameter int unsigned CNT_ADDR = 'h101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_on_err_i,
  input  logic              eom_i,
  input  logic [15:0]       tag_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              bc_start_o,
  output logic [ADDR_W-1:0] data_addr_o,
  output logic              busy_o,
  output logic              eom_evt_o,
  output logic              err_evt_o,
  output logic              done_evt_o,
  output logic              capture_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [15:0]       cnt_o,
  input  logic [ADDR_W-1:0] ptr_next_i,
  input  logic [15:0]       cnt_next_i,
  input  logic              cnt_last_i,
  input  logic [15:0]       bsw_i,
  input  logic              any_err_i
);
  import bc_seq_pkg::*;

  localparam logic [ADDR_W-1:0] SP_LOC  = ADDR_W'(SP_ADDR);
  localparam logic [ADDR_W-1:0] CNT_LOC = ADDR_W'(CNT_ADDR);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] dba_q;
  logic [15:0]       cnt_q;
  logic [15:0]       tag_q;
  logic              eom_q, err_q, done_q;
  logic              acc;
  logic              halt;

  assign acc  = mem_valid_o & mem_ready_i;
  assign halt = cnt_last_i | (any_err_i & stop_on_err_i);

  // request decode
  always_comb begin
    mem_valid_o = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_RD_SP:   mem_addr_o = SP_LOC;
      ST_WR_SOM:  begin mem_we_o = 1'b1; mem_addr_o = sp_q; mem_wdata_o = 16'(1) << BSW_BUSY; end
      ST_WR_TAG0,
      ST_WR_TAG1: begin mem_we_o = 1'b1; mem_addr_o = sp_q + ADDR_W'(1); mem_wdata_o = tag_q; end
      ST_RD_DBA:  mem_addr_o = sp_q + ADDR_W'(3);
      ST_WR_BSW:  begin mem_we_o = 1'b1; mem_addr_o = sp_q; mem_wdata_o = bsw_i; end
      ST_WR_SP:   begin mem_we_o = 1'b1; mem_addr_o = SP_LOC; mem_wdata_o = 16'(ptr_next_i); end
      ST_RD_CNT:  mem_addr_o = CNT_LOC;
      ST_WR_CNT:  begin mem_we_o = 1'b1; mem_addr_o = CNT_LOC; mem_wdata_o = cnt_next_i; end
      default:    mem_valid_o = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_RD_SP;
      ST_RD_SP:    if (acc) state_d = ST_RD_SP_D;
      ST_RD_SP_D:  state_d = ST_WR_SOM;
      ST_WR_SOM:   if (acc) state_d = ST_WR_TAG0;
      ST_WR_TAG0:  if (acc) state_d = ST_RD_DBA;
      ST_RD_DBA:   if (acc) state_d = ST_RD_DBA_D;
      ST_RD_DBA_D: state_d = ST_KICK;
      ST_KICK:     state_d = ST_WAIT;
      ST_WAIT:     if (eom_i) state_d = ST_WR_BSW;
      ST_WR_BSW:   if (acc) state_d = ST_WR_TAG1;
      ST_WR_TAG1:  if (acc) state_d = ST_WR_SP;
      ST_WR_SP:    if (acc) state_d = ST_RD_CNT;
      ST_RD_CNT:   if (acc) state_d = ST_RD_CNT_D;
      ST_RD_CNT_D: state_d = ST_WR_CNT;
      ST_WR_CNT:   if (acc) state_d = halt ? ST_IDLE : ST_RD_SP;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= '0;
      dba_q   <= '0;
      cnt_q   <= '0;
      tag_q   <= '0;
      eom_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      eom_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      if (state_q == ST_RD_SP_D)  sp_q  <= mem_rdata_i[ADDR_W-1:0];
      if (state_q == ST_RD_DBA_D) dba_q <= mem_rdata_i[ADDR_W-1:0];
      if (state_q == ST_RD_CNT_D) cnt_q <= mem_rdata_i;
      if ((state_q == ST_WR_SOM && acc) || (state_q == ST_WAIT && eom_i)) tag_q <= tag_i;
      if (state_q == ST_WR_CNT && acc) begin
        eom_q  <= 1'b1;
        err_q  <= any_err_i;
        done_q <= cnt_last_i;
      end
    end
  end

  assign capture_o   = (state_q == ST_WAIT) & eom_i;
  assign bc_start_o  = (state_q == ST_KICK);
  assign busy_o      = (state_q != ST_IDLE);
  assign data_addr_o = dba_q;
  assign eom_evt_o   = eom_q;
  assign err_evt_o   = err_q;
  assign done_evt_o  = done_q;
  assign sp_o        = sp_q;
  assign cnt_o       = cnt_q;

endmodule

// File: rtl/bc_desc_seq.sv
module bc_desc_seq #(
  parameter int ADDR_W        = 16,
  parameter int STACK_ENTRIES = 64,
  parameter int unsigned SP_ADDR  = 'h100,
  parameter int unsigned CNT_ADDR = 'h101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_on_err_i,
  input  logic              eom_i,
  input  logic              loop_fail_i,
  input  logic              timeout_i,
  input  logic              format_err_i,
  input  logic              status_set_i,
  input  logic [15:0]       tag_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  output logic              bc_start_o,
  output logic [ADDR_W-1:0] data_addr_o,
  output logic              busy_o,
  output logic              eom_evt_o,
  output logic              err_evt_o,
  output logic              done_evt_o
);

  logic [ADDR_W-1:0] sp, ptr_next;
  logic [15:0]       cnt, cnt_next, bsw;
  logic              cnt_last, capture, any_err;

  bc_seq_ptr #(.ADDR_W(ADDR_W), .STACK_ENTRIES(STACK_ENTRIES)) u_ptr (
    .ptr_i      (sp),
    .ptr_next_o (ptr_next),
    .cnt_i      (cnt),
    .cnt_next_o (cnt_next),
    .cnt_last_o (cnt_last)
  );

  bc_seq_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture_i    (capture),
    .loop_fail_i  (loop_fail_i),
    .timeout_i    (timeout_i),
    .format_err_i (format_err_i),
    .status_set_i (status_set_i),
    .bsw_o        (bsw),
    .any_err_o    (any_err)
  );

  bc_seq_fsm #(.ADDR_W(ADDR_W), .SP_ADDR(SP_ADDR), .CNT_ADDR(CNT_ADDR)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .stop_on_err_i (stop_on_err_i),
    .eom_i         (eom_i),
    .tag_i         (tag_i),
    .mem_valid_o   (mem_valid_o),
    .mem_ready_i   (mem_ready_i),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_rdata_i   (mem_rdata_i),
    .bc_start_o    (bc_start_o),
    .data_addr_o   (data_addr_o),
    .busy_o        (busy_o),
    .eom_evt_o     (eom_evt_o),
    .err_evt_o     (err_evt_o),
    .done_evt_o    (done_evt_o),
    .capture_o     (capture),
    .sp_o          (sp),
    .cnt_o         (cnt),
    .ptr_next_i    (ptr_next),
    .cnt_next_i    (cnt_next),
    .cnt_last_i    (cnt_last),
    .bsw_i         (bsw),
    .any_err_i     (any_err)
  );

endmodule

// File: rtl/bc_desc_seq_chk.sv
module bc_desc_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int unsigned SP_ADDR = 'h100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              bc_start_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [15:0]       mem_wdata_o,
  input logic              eom_evt_o,
  input logic              err_evt_o,
  input logic              done_evt_o
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R9

  AST_FIRST_REQ_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> mem_valid_o && !mem_we_o && mem_addr_o == ADDR_W'(SP_ADDR)); // R2

  AST_KICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bc_start_o |=> !bc_start_o); // R2

  AST_ERR_WITH_EOM: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_o |-> eom_evt_o); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt_o |-> eom_evt_o && !busy_o); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_valid_o && !bc_start_o); // R1

endmodule

bind bc_desc_seq bc_desc_seq_chk #(.ADDR_W(ADDR_W), .SP_ADDR(SP_ADDR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .bc_start_o  (bc_start_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .eom_evt_o   (eom_evt_o),
  .err_evt_o   (err_evt_o),
  .done_evt_o  (done_evt_o)
);

// File: tb/bc_desc_seq_tb.sv
module bc_desc_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int SPL = 'h100;
  localparam int CNL = 'h101;
  localparam logic [15:0] TAG_A = 16'h1A1A;
  localparam logic [15:0] TAG_B = 16'h2B2B;

  logic clk = 1'b0;
  logic rst_n, start_i, start_cmd, start_poke, stop_on_err, eom_i;
  logic loop_fail, timeout, format_err, status_set, tag_phase;
  logic [15:0] tag_i, mem_wdata, mem_rdata;
  logic mem_valid, mem_ready, mem_we, bc_start, busy, eom_evt, err_evt, done_evt;
  logic [AW-1:0] mem_addr, data_addr;

  logic [15:0] ram [0:4095];
  logic [3:0]  plan [0:15];
  int checks = 0, errors = 0, cyc = 0;
  int n_eom = 0, n_err = 0, n_done = 0, n_kick = 0, run_base = 0, eom_dly = 0;
  bit poke_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign start_i = start_cmd | start_poke;
  assign tag_i   = tag_phase ? TAG_B : TAG_A;

  bc_desc_seq #(.ADDR_W(AW), .STACK_ENTRIES(64), .SP_ADDR(SPL), .CNT_ADDR(CNL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_on_err_i(stop_on_err), .eom_i(eom_i),
    .loop_fail_i(loop_fail), .timeout_i(timeout), .format_err_i(format_err), .status_set_i(status_set),
    .tag_i(tag_i), .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .bc_start_o(bc_start), .data_addr_o(data_addr), .busy_o(busy),
    .eom_evt_o(eom_evt), .err_evt_o(err_evt), .done_evt_o(done_evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] wrap(input logic [11:0] b, input int i);
    return (b & 12'hF00) | 12'((int'(b & 12'h0FF) + 4 * i) % 256);
  endfunction

  function automatic logic [15:0] bsw_of(input logic [3:0] f);
    return 16'h0001 | (16'(f) << 8) | (16'(f != 4'd0) << 12);
  endfunction

  // RAM model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else mem_rdata <= ram[mem_addr];
    end
  end

  // ready pattern, protocol device model, event counters, watchdog
  always @(negedge clk) begin
    logic [11:0] d;
    cyc++;
    mem_ready = (cyc % 5) != 2;
    start_poke = 1'b0;
    eom_i = 1'b0;
    {loop_fail, timeout, format_err, status_set} = 4'b0;
    if (eom_evt) begin n_eom++; tag_phase = 1'b0; end
    if (err_evt) n_err++;
    if (done_evt) n_done++;
    if (eom_dly > 0) begin
      eom_dly--;
      if (eom_dly == 0) begin
        eom_i = 1'b1;
        {loop_fail, timeout, format_err, status_set} = plan[(n_kick - run_base - 1) % 16];
      end
    end
    if (bc_start) begin
      d = ram[SPL][11:0];
      chk("R2 som word", 32'(ram[d]), 32'h0002);
      chk("R2 start tag", 32'(ram[d + 12'd1]), 32'(TAG_A));
      chk("R2 data addr", 32'(data_addr), 32'(ram[d + 12'd3][11:0]));
      n_kick++;
      tag_phase = 1'b1;
      eom_dly = 4;
      if (poke_en) start_poke = 1'b1;
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R6 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic setup(input logic [11:0] sp0, input int n);
    ram[SPL] = 16'(sp0);
    ram[CNL] = 16'hFFFF - 16'(n);
    for (int i = 0; i < n; i++) begin
      logic [11:0] d;
      d = wrap(sp0, i);
      ram[d] = 16'hDEAD;
      ram[d + 12'd1] = 16'h0;
      ram[d + 12'd2] = 16'h5A5A;
      ram[d + 12'd3] = 16'h0A00 + 16'(d);
    end
  endtask

  task automatic do_run(input logic [11:0] sp0, input int remaining, input int p_exp, input logic stop);
    int b_eom, b_err, b_done, b_kick, e;
    b_eom = n_eom; b_err = n_err; b_done = n_done; b_kick = n_kick;
    run_base = n_kick;
    stop_on_err = stop;
    @(negedge clk) start_cmd = 1'b1;
    @(negedge clk) start_cmd = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    e = 0;
    for (int i = 0; i < p_exp; i++) begin
      logic [11:0] d;
      d = wrap(sp0, i);
      chk("R4 status word", 32'(ram[d]), 32'(bsw_of(plan[i])));
      chk("R4 end tag", 32'(ram[d + 12'd1]), 32'(TAG_B));
      if (plan[i] != 4'd0) e++;
    end
    chk("R5 pointer", 32'(ram[SPL]), 32'(wrap(sp0, p_exp)));
    chk("R6 count", 32'(ram[CNL]), 32'(16'hFFFF - 16'(remaining) + 16'(p_exp)));
    chk("R7 eom events", 32'(n_eom - b_eom), 32'(p_exp));
    chk("R7 err events", 32'(n_err - b_err), 32'(e));
    chk("R6 done events", 32'(n_done - b_done), 32'(p_exp == remaining));
    chk("R3 kicks", 32'(n_kick - b_kick), 32'(p_exp));
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) ram[i] = 16'h0;
    for (int i = 0; i < 16; i++) plan[i] = 4'd0;
    rst_n = 1'b0; start_cmd = 1'b0; stop_on_err = 1'b0; poke_en = 1'b0; tag_phase = 1'b0;
    mem_rdata = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 0);
    chk("R1 valid in reset", 32'(mem_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 kick", 32'(bc_start), 0);
    chk("R1 events", 32'({eom_evt, err_evt, done_evt}), 0);

    // R5 wrap across end of stack, R9 with stalls
    setup(12'h4F8, 3);
    do_run(12'h4F8, 3, 3, 1'b0);

    // R8 halt on timeout, then resume
    plan[1] = 4'b0100;
    setup(12'h410, 4);
    do_run(12'h410, 4, 2, 1'b1);
    plan[1] = 4'b0000;
    do_run(wrap(12'h410, 2), 2, 2, 1'b1);

    // R10 errors without stop
    plan[0] = 4'b1000; plan[2] = 4'b0001;
    setup(12'h520, 3);
    do_run(12'h520, 3, 3, 1'b0);
    plan[0] = 4'b0; plan[2] = 4'b0;

    // last message with error and stop set: done and err together
    plan[0] = 4'b0010;
    setup(12'h580, 1);
    do_run(12'h580, 1, 1, 1'b1);

    // R3 start poked while busy
    plan[0] = 4'b0;
    poke_en = 1'b1;
    setup(12'h5C0, 2);
    do_run(12'h5C0, 2, 2, 1'b0);
    poke_en = 1'b0;

    // R4 every error pattern on a one-message list
    for (int f = 0; f < 16; f++) begin
      plan[0] = 4'(f);
      setup(12'h600 + 12'(8 * f), 1);
      do_run(12'h600 + 12'(8 * f), 1, 1, f[0]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule